// File: doc/BRIEF.md
# PHY Test-Port Register Write Sequencer

This block writes a PHY's internal 8-bit configuration registers through a bit-banged test port. It uses a test clock, an address/data select line, a clear line and one shared 8-bit data bus. One write has two parts. In the address part the select line is high and the target address sits on the bus; the PHY takes the address when the test clock falls. In the data part the select line is low and the value sits on the bus; the PHY takes the value when the test clock rises. Each high and low stretch of the test clock lasts a programmable number of system cycles.

On top of the single-write engine sits a fixed five-step script that programs the PHY's PLL. A one-cycle start pulse carries the feedback multiplier M, the input divider N and a frequency-range code. The script then writes the following registers in turn:

- the range register
- an override-enable register
- the divider register
- the multiplier register, twice: first its low field, then its high field with a marker bit set

A one-cycle done pulse marks the end of the script. The clear line is held active only during system reset and stays inactive at all other times.

Top module: `phy_tp_seq`

## Requirements
- R1: While `rst_n` is low, at the next clock edge the block sets `tp_clk`=0, `tp_sel`=0, `tp_clr`=1, `busy`=0 and `done`=0.
- R2: Once reset is released, `tp_clr` stays 0, and `tp_clk` and `tp_sel` stay 0 whenever `busy` is low.
- R3: Every write begins with an address part. `tp_sel` is 1 throughout, the address is steady on `tp_data`, and `tp_clk` makes one pulse. The address is valid at the falling edge of that pulse.
- R4: The data part follows the address part. `tp_sel` is 0 throughout, the value is steady on `tp_data`, and `tp_clk` makes one pulse. The value is valid at the rising edge of that pulse. `tp_data` and `tp_sel` never change while `tp_clk` is high.
- R5: Each write is six phases of H system cycles each, in this order: low, high, low, low, high, low. H is `half_len` sampled when the write starts, and a `half_len` of 0 counts as 1.
- R6: The script starts with three writes, in order: address 0x44 with data {range,0}, then address 0x19 with data 0x30, then address 0x17 with data N-1 (8 bits).
- R7: The script then writes address 0x18 twice. Let K = (M-1) mod 512. The first write carries K[4:0] in bits 4:0 and zeros above. The second carries 0x80 | K[8:5].
- R8: A start pulse that arrives while `busy` is high is ignored. The current script and its captured operands are unchanged, and no extra run follows.
- R9: `done` is high for exactly one cycle. If the start pulse is sampled at edge 0, `done` is visible after edge 5·(6H+1), and `busy` is low from the next edge on.
- R10: A start pulse accepted while idle makes `busy` high from the next cycle until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the PLL script |
| m_in | input | M_W (10) | Feedback multiplier M |
| n_in | input | N_W (8) | Input divider N |
| range_in | input | RANGE_W (7) | Frequency-range select code |
| half_len | input | HALF_W (4) | System cycles per test-clock phase (0 means 1) |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse after the last write |
| tp_clk | output | 1 | Test clock to the PHY |
| tp_clr | output | 1 | Test clear, active high, active only in reset |
| tp_sel | output | 1 | High in the address part, low in the data part |
| tp_data | output | 8 | Address or value presented to the PHY |

## Verification
The assertions check on every cycle that the port is quiet in reset and when idle, that the bus and select line hold still while the test clock is high, that `done` lasts one cycle and ends `busy`, and that an accepted start raises `busy`. Some behaviours need the bench's scenarios, which run a register-capture model of the PHY. These are the address and value sequence of the script, the split of M-1 into two fields, the exact phase widths and end-to-end latency for each `half_len`, and the operands staying unchanged when a start pulse arrives mid-run.

// File: rtl/phy_tp_pkg.sv
// Package: shared types and the fixed PLL register script for the test-port sequencer.
// Assumes 8-bit PHY register addresses and values.
package phy_tp_pkg;

    localparam int unsigned STEPS = 5;

    // Phases of one test-port write; the order is the wire-level order.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_A_SET,
        PH_A_HI,
        PH_A_LO,
        PH_D_SET,
        PH_D_HI,
        PH_D_LO
    } phase_e;

    // Script step: the PHY register address written at step k.
    function automatic logic [7:0] step_addr(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h44;
            3'd1:    return 8'h19;
            3'd2:    return 8'h17;
            default: return 8'h18;
        endcase
    endfunction

    // Script step: the value written at step k, from range code, N-1 and M-1.
    function automatic logic [7:0] step_data(input logic [2:0] k, input logic [6:0] rng,
                                             input logic [7:0] nm1, input logic [8:0] mm1);
        case (k)
            3'd0:    return {rng, 1'b0};
            3'd1:    return 8'h30;
            3'd2:    return nm1;
            3'd3:    return {3'b000, mm1[4:0]};
            default: return {4'h8, mm1[8:5]};
        endcase
    endfunction

endpackage

// File: rtl/tp_write_engine.sv
// Module: single-register write engine on the PHY test port.
// One req pulse starts a write of wr_addr/wr_data. Six phases of H cycles follow.
// ack is high in the last cycle of the write. Assumes req arrives only when idle.
module tp_write_engine
    import phy_tp_pkg::*;
#(
    parameter int unsigned HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [HALF_W-1:0] half_len,
    output logic              ack,
    output logic              tp_clk,
    output logic              tp_sel,
    output logic [7:0]        tp_data
);

    phase_e            ph_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] len_q;
    logic [7:0]        addr_q;
    logic [7:0]        data_q;
    logic [HALF_W-1:0] len_m1;

    // Phase length minus one; a zero length is treated as one cycle.
    always_comb len_m1 = (half_len == '0) ? '0 : half_len - 1'b1;

    // Phase sequencing and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            len_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (req) begin
                ph_q   <= PH_A_SET;
                cnt_q  <= len_m1;
                len_q  <= len_m1;
                addr_q <= wr_addr;
                data_q <= wr_data;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            cnt_q <= len_q;
            case (ph_q)
                PH_A_SET: ph_q <= PH_A_HI;
                PH_A_HI:  ph_q <= PH_A_LO;
                PH_A_LO:  ph_q <= PH_D_SET;
                PH_D_SET: ph_q <= PH_D_HI;
                PH_D_HI:  ph_q <= PH_D_LO;
                default:  ph_q <= PH_IDLE;
            endcase
        end
    end

    // Port pins decoded together from the phase so they change in the same cycle.
    always_comb begin
        tp_clk  = (ph_q == PH_A_HI) || (ph_q == PH_D_HI);
        tp_sel  = (ph_q == PH_A_SET) || (ph_q == PH_A_HI) || (ph_q == PH_A_LO);
        tp_data = tp_sel ? addr_q : ((ph_q == PH_IDLE) ? 8'h00 : data_q);
        ack     = (ph_q == PH_D_LO) && (cnt_q == '0);
    end

endmodule

// File: rtl/tp_pll_script.sv
// Module: fixed five-step PLL programming script.
// Latches M, N and range on an accepted start and issues one engine write per step.
// Pulses done after the last ack. Starts that arrive while busy are dropped.
module tp_pll_script
    import phy_tp_pkg::*;
#(
    parameter int unsigned M_W     = 10,
    parameter int unsigned N_W     = 8,
    parameter int unsigned RANGE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [M_W-1:0]     m_in,
    input  logic [N_W-1:0]     n_in,
    input  logic [RANGE_W-1:0] range_in,
    input  logic               wr_ack,
    output logic               wr_req,
    output logic [7:0]         wr_addr,
    output logic [7:0]         wr_data,
    output logic               busy,
    output logic               done
);

    localparam logic [2:0] LAST = 3'(STEPS - 1);

    typedef enum logic [1:0] {SC_IDLE, SC_REQ, SC_WAIT, SC_DONE} sc_e;

    sc_e                sc_q;
    logic [2:0]         step_q;
    logic [M_W-1:0]     m_q;
    logic [N_W-1:0]     n_q;
    logic [RANGE_W-1:0] r_q;
    logic [15:0]        mm1;
    logic [15:0]        nm1;

    // Operand arithmetic, wrapped to the field widths the PHY uses.
    always_comb begin
        mm1 = 16'(m_q) - 16'd1;
        nm1 = 16'(n_q) - 16'd1;
    end

    // Script state, step index and operand latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q   <= SC_IDLE;
            step_q <= '0;
            m_q    <= '0;
            n_q    <= '0;
            r_q    <= '0;
        end else begin
            case (sc_q)
                SC_IDLE: if (start) begin
                    sc_q   <= SC_REQ;
                    step_q <= '0;
                    m_q    <= m_in;
                    n_q    <= n_in;
                    r_q    <= range_in;
                end
                SC_REQ:  sc_q <= SC_WAIT;
                SC_WAIT: if (wr_ack) begin
                    if (step_q == LAST) begin
                        sc_q <= SC_DONE;
                    end else begin
                        sc_q   <= SC_REQ;
                        step_q <= step_q + 3'd1;
                    end
                end
                default: sc_q <= SC_IDLE;
            endcase
        end
    end

    // Request and operand outputs for the current step.
    always_comb begin
        wr_req  = (sc_q == SC_REQ);
        wr_addr = step_addr(step_q);
        wr_data = step_data(step_q, 7'(r_q), nm1[7:0], mm1[8:0]);
        busy    = (sc_q != SC_IDLE);
        done    = (sc_q == SC_DONE);
    end

endmodule

// File: rtl/phy_tp_seq.sv
// Module: top of the PHY test-port register write sequencer.
// The script drives the write engine. The clear line is registered: active in reset, inactive after.
module phy_tp_seq
    import phy_tp_pkg::*;
#(
    parameter int unsigned M_W     = 10,
    parameter int unsigned N_W     = 8,
    parameter int unsigned RANGE_W = 7,
    parameter int unsigned HALF_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [M_W-1:0]     m_in,
    input  logic [N_W-1:0]     n_in,
    input  logic [RANGE_W-1:0] range_in,
    input  logic [HALF_W-1:0]  half_len,
    output logic               busy,
    output logic               done,
    output logic               tp_clk,
    output logic               tp_clr,
    output logic               tp_sel,
    output logic [7:0]         tp_data
);

    logic       wr_req;
    logic       wr_ack;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    // Clear line: held active during reset, released for every access afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) tp_clr <= 1'b1;
        else        tp_clr <= 1'b0;
    end

    tp_pll_script #(.M_W(M_W), .N_W(N_W), .RANGE_W(RANGE_W)) u_script (
        .clk(clk), .rst_n(rst_n), .start(start), .m_in(m_in), .n_in(n_in),
        .range_in(range_in), .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    tp_write_engine #(.HALF_W(HALF_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .half_len(half_len), .ack(wr_ack), .tp_clk(tp_clk), .tp_sel(tp_sel),
        .tp_data(tp_data)
    );

endmodule

// File: rtl/phy_tp_seq_chk.sv
// Checker: cycle-level port rules of the test-port sequencer, bound into the top.
module phy_tp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       tp_clk,
    input logic       tp_clr,
    input logic       tp_sel,
    input logic [7:0] tp_data
);

    // R1: a reset edge leaves the port quiet with clear active.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tp_clk && !tp_sel && tp_clr && !busy && !done));

    // R2: clear inactive after reset, clock and select low while idle.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> (!tp_clr && (busy || (!tp_clk && !tp_sel))));

    // R3/R4: bus and select hold still while the test clock stays high.
    a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_clk && $past(tp_clk)) |-> ($stable(tp_data) && $stable(tp_sel)));

    // R3: address steady for the whole address part.
    a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_sel && $past(tp_sel)) |-> $stable(tp_data));

    // R9: done lasts one cycle and ends busy.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: an accepted start raises busy.
    a_r10_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind phy_tp_seq phy_tp_seq_chk u_chk (.*);

// File: tb/phy_tp_seq_tb.sv
// Bench: sweeps phase length and operand sets against a PHY register-capture model.
module phy_tp_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] m_in = '0;
    logic [7:0] n_in = '0;
    logic [6:0] range_in = '0;
    logic [3:0] half_len = 4'd1;
    logic       busy, done, tp_clk, tp_clr, tp_sel;
    logic [7:0] tp_data;

    int errs = 0;
    int checks = 0;

    // Capture model state.
    logic [7:0] cap_a [0:7];
    logic [7:0] cap_d [0:7];
    int   n_addr = 0;
    int   n_data = 0;
    int   hi_run = 0;
    int   bad_width = 0;
    int   cur_h = 1;
    logic prev_clk = 1'b0;
    logic [7:0] pend_a = '0;

    always #2.5 clk = ~clk;

    phy_tp_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .m_in(m_in), .n_in(n_in),
        .range_in(range_in), .half_len(half_len), .busy(busy), .done(done),
        .tp_clk(tp_clk), .tp_clr(tp_clr), .tp_sel(tp_sel), .tp_data(tp_data)
    );

    // PHY model: sampled mid-cycle. Address taken on a falling edge with select high.
    // Value taken on a rising edge with select low. High widths are measured.
    always @(negedge clk) begin
        if (!prev_clk && tp_clk) begin
            if (!tp_sel && n_data < 8) begin
                cap_a[n_data] = pend_a;
                cap_d[n_data] = tp_data;
                n_data++;
            end
        end
        if (prev_clk && !tp_clk) begin
            if (tp_sel) begin
                pend_a = tp_data;
                n_addr++;
            end
            if (hi_run != cur_h) bad_width++;
        end
        hi_run   = tp_clk ? hi_run + 1 : 0;
        prev_clk = tp_clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // One script run with expected values computed from M, N, range and H.
    task automatic run_case(input int h, input int m, input int n, input int r, input bit inject);
        int cyc;
        int mm1;
        int exp_lat;
        cur_h   = (h == 0) ? 1 : h;
        mm1     = (m - 1) & 9'h1FF;
        exp_lat = 5 * (6 * cur_h + 1) + 1;
        n_addr = 0; n_data = 0; bad_width = 0;
        @(negedge clk);
        half_len = 4'(h); m_in = 10'(m); n_in = 8'(n); range_in = 7'(r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", busy, 1);
        cyc = 1;
        while (!done && cyc < 2000) begin
            if (inject && cyc == 7) begin
                start = 1'b1; m_in = 10'(m ^ 10'h155); n_in = 8'(n + 3); range_in = 7'(r ^ 7'h2A);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (!done && !busy) begin
                errs++; checks++;
                $display("FAIL R10: busy dropped early actual=0 expected=1");
            end
        end
        start = 1'b0;
        check("R9 latency", cyc, exp_lat);
        @(negedge clk);
        check("R9 done single cycle", done, 0);
        check("R9 busy low after done", busy, 0);
        check("R3 address parts", n_addr, 5);
        check("R4 data parts", n_data, 5);
        check("R5 high widths", bad_width, 0);
        check("R6 step0 addr", cap_a[0], 8'h44);
        check("R6 step0 data", cap_d[0], 8'((r << 1) & 8'hFE));
        check("R6 step1", {cap_a[1], cap_d[1]}, 16'h1930);
        check("R6 step2", {cap_a[2], cap_d[2]}, {8'h17, 8'((n - 1) & 8'hFF)});
        check("R7 M low", {cap_a[3], cap_d[3]}, {8'h18, 8'(mm1 & 5'h1F)});
        check("R7 M high", {cap_a[4], cap_d[4]}, {8'h18, 8'(8'h80 | ((mm1 >> 5) & 4'hF))});
        if (inject) begin
            repeat (4) @(negedge clk);
            check("R8 no extra run", {busy, tp_clk}, 2'b00);
            check("R8 no extra writes", n_data, 5);
        end
        check("R2 idle port", {tp_clk, tp_sel, tp_clr}, 3'b000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset clk", tp_clk, 0);
        check("R1 reset sel", tp_sel, 0);
        check("R1 reset clr", tp_clr, 1);
        check("R1 reset busy/done", {busy, done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 clr released", tp_clr, 0);
        for (int h = 0; h < 4; h++) begin
            run_case(h, 2, 1, 0, 0);
            run_case(h, 32, 2, 7'h7F, 0);
            run_case(h, 33, 255, 7'h15, h == 1);
            run_case(h, 514, 40, 7'h40, 0);
            run_case(h, 1023, 8, 7'h01, h == 3);
            run_case(h, 64, 0, 7'h2A, 0);
        end
        finish_run();
    end

endmodule